// File: doc/BRIEF.md
# Countdown Issue Queue with Poison Replay

This block is the execution queue that sits in front of one functional unit. Micro-ops reach it with an issue time already fixed by an earlier stage, given as a cycle delay. Each entry counts that delay down and is released to the unit when the count reaches zero. The queue does no operand wakeup and no readiness check, because the scheduler upstream has already placed every consumer after its producers.

When a producer's latency guess proves wrong, its result is marked poisoned and its tag is broadcast. Each entry watches the broadcast against its own source tags. An entry whose source is poisoned is not sent to the unit when it expires. It raises a replay request carrying its tag and stays in the queue, parked, until the rescheduler returns that tag with a new delay. The countdown then restarts. This can happen any number of times, for example once per cache level a load misses.

Top module: `countdown_issue_queue`

## Requirements
- R1: After reset the queue is empty: issueValid and replayValid are low and enqFull is low.
- R2: An op accepted with delay D in cycle t is presented on the issue port, with its op and tag, in cycle t+1+D exactly once, whatever its source tags.
- R3: At most one entry leaves per cycle. When several expire together the one enqueued earliest leaves first, and each loser leaves in a following cycle.
- R4: enqFull is high exactly when all DEPTH entries are occupied. An enqueue presented while enqFull is high is dropped and never issues.
- R5: A poison broadcast (poisonValid with poisonTag) that matches a source tag of a waiting entry causes that entry, on expiry, to leave issueValid low and raise replayValid with replayTag equal to its tag.
- R6: A poison broadcast in the very cycle an entry expires also suppresses its issue and raises the replay request.
- R7: A replayed entry stays in the queue with its op and tag. It never issues until reschedValid arrives with its tag and a delay D' in cycle r, and then it issues in cycle r+1+D' with its poison marks cleared.
- R8: An entry can be poisoned and replayed repeatedly and still issue once its sources are clean.
- R9: A poison broadcast whose tag matches no source tag of an entry has no effect on that entry's issue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| enqValid | input | 1 | Enqueue request |
| enqOp | input | OP_W | Micro-op payload |
| enqTag | input | TAG_W | Result tag of the micro-op |
| enqDelay | input | DLY_W | Cycles to wait before issue |
| enqSrcTags | input | NSRC*TAG_W | Source tags, source 0 in the low bits |
| enqFull | output | 1 | All entries occupied; enqueue dropped |
| issueValid | output | 1 | Op sent to the functional unit this cycle |
| issueOp | output | OP_W | Issued op payload |
| issueTag | output | TAG_W | Issued op tag |
| poisonValid | input | 1 | Poison broadcast strobe |
| poisonTag | input | TAG_W | Tag of the poisoned result |
| replayValid | output | 1 | Expired op needs re-execution |
| replayTag | output | TAG_W | Tag of the op to reschedule |
| reschedValid | input | 1 | New issue time for a parked op |
| reschedTag | input | TAG_W | Tag of the parked op |
| reschedDelay | input | DLY_W | New delay for the parked op |

## Verification
A lone op with a long delay separates correct countdown timing from an off-by-one. Two ops enqueued in different cycles that expire together show whether age, and not slot index, picks the winner and whether the loser is held back rather than lost. A burst that fills the queue, followed by a request while full, shows whether the dropped op ever leaks out. Poison arriving before expiry, in the expiry cycle, twice in a row, and with a non-matching tag separates stored poison marks, the same-cycle check, the clearing of marks on reschedule and false matches.

// File: rtl/cq_pkg.sv
package cq_pkg;
  localparam int MAX_DEPTH = 32;
  localparam int IDX_W = $clog2(MAX_DEPTH);

  typedef struct packed {
    logic             enq;
    logic [IDX_W-1:0] enqIdx;
    logic             fire;
    logic             fireReplay;
    logic [IDX_W-1:0] fireIdx;
  } cqStrobes_t;
endpackage

// File: rtl/cq_ctrl.sv
module cq_ctrl
  import cq_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enqValid,
  input  logic [DEPTH-1:0] occMask,
  input  logic [DEPTH-1:0] readyMask,
  input  logic [DEPTH-1:0] poisonMask,
  output cqStrobes_t       strobes,
  output logic             enqFull
);
  logic [DEPTH-1:0] olderThan [DEPTH];
  logic [DEPTH-1:0] freeMask;
  logic             haveFree;
  logic [IDX_W-1:0] freeIdx;
  logic             winFound;
  logic [IDX_W-1:0] winIdx;
  logic             winPoison;

  assign enqFull = &occMask;

  always_comb begin
    haveFree = 1'b0;
    freeIdx  = '0;
    for (int i = DEPTH - 1; i >= 0; i--) begin
      if (!occMask[i]) begin
        haveFree = 1'b1;
        freeIdx  = IDX_W'(i);
      end
    end
  end

  always_comb begin
    winFound  = 1'b0;
    winIdx    = '0;
    winPoison = 1'b0;
    for (int i = 0; i < DEPTH; i++) begin
      if (readyMask[i] && ((olderThan[i] & readyMask) == '0)) begin
        winFound  = 1'b1;
        winIdx    = IDX_W'(i);
        winPoison = poisonMask[i];
      end
    end
  end

  always_comb begin
    strobes.enq        = enqValid && haveFree;
    strobes.enqIdx     = freeIdx;
    strobes.fire       = winFound;
    strobes.fireReplay = winFound && winPoison;
    strobes.fireIdx    = winIdx;
    freeMask           = '0;
    for (int i = 0; i < DEPTH; i++) begin
      freeMask[i] = winFound && !winPoison && (winIdx == IDX_W'(i));
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) olderThan[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (strobes.enq && (strobes.enqIdx == IDX_W'(i)))
          olderThan[i] <= occMask & ~freeMask;
        else
          olderThan[i] <= olderThan[i] & ~freeMask;
      end
    end
  end
endmodule

// File: rtl/cq_entries.sv
module cq_entries
  import cq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int OP_W  = 8,
  parameter int TAG_W = 6,
  parameter int DLY_W = 4,
  parameter int NSRC  = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  cqStrobes_t            strobes,
  input  logic [OP_W-1:0]       enqOp,
  input  logic [TAG_W-1:0]      enqTag,
  input  logic [DLY_W-1:0]      enqDelay,
  input  logic [NSRC*TAG_W-1:0] enqSrcTags,
  input  logic                  poisonValid,
  input  logic [TAG_W-1:0]      poisonTag,
  input  logic                  reschedValid,
  input  logic [TAG_W-1:0]      reschedTag,
  input  logic [DLY_W-1:0]      reschedDelay,
  output logic [DEPTH-1:0]      occMask,
  output logic [DEPTH-1:0]      readyMask,
  output logic [DEPTH-1:0]      poisonMask,
  output logic                  issueValid,
  output logic [OP_W-1:0]       issueOp,
  output logic [TAG_W-1:0]      issueTag,
  output logic                  replayValid,
  output logic [TAG_W-1:0]      replayTag
);
  logic [DEPTH-1:0] parked;
  logic [DLY_W-1:0] cnt     [DEPTH];
  logic [OP_W-1:0]  opQ     [DEPTH];
  logic [TAG_W-1:0] tagQ    [DEPTH];
  logic [TAG_W-1:0] srcQ    [DEPTH][NSRC];
  logic [NSRC-1:0]  psn     [DEPTH];
  logic [NSRC-1:0]  hitNow  [DEPTH];
  logic [NSRC-1:0]  enqHit;
  logic [DEPTH-1:0] reschedHit;
  logic [DEPTH-1:0] selMask;
  logic [DEPTH-1:0] enqSel;

  always_comb begin
    for (int s = 0; s < NSRC; s++)
      enqHit[s] = poisonValid && (poisonTag == enqSrcTags[s*TAG_W +: TAG_W]);
    for (int i = 0; i < DEPTH; i++) begin
      for (int s = 0; s < NSRC; s++)
        hitNow[i][s] = poisonValid && (poisonTag == srcQ[i][s]);
      poisonMask[i] = |(psn[i] | hitNow[i]);
      readyMask[i]  = occMask[i] && !parked[i] && (cnt[i] == '0);
      reschedHit[i] = reschedValid && occMask[i] && parked[i] && (tagQ[i] == reschedTag);
      selMask[i]    = strobes.fire && (strobes.fireIdx == IDX_W'(i));
      enqSel[i]     = strobes.enq && (strobes.enqIdx == IDX_W'(i));
    end
  end

  always_comb begin
    issueOp  = '0;
    issueTag = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (selMask[i]) begin
        issueOp  = opQ[i];
        issueTag = tagQ[i];
      end
    end
    issueValid  = strobes.fire && !strobes.fireReplay;
    replayValid = strobes.fire && strobes.fireReplay;
    replayTag   = issueTag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      occMask <= '0;
      parked  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        cnt[i]  <= '0;
        opQ[i]  <= '0;
        tagQ[i] <= '0;
        psn[i]  <= '0;
        for (int s = 0; s < NSRC; s++) srcQ[i][s] <= '0;
      end
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        if (enqSel[i]) begin
          occMask[i] <= 1'b1;
          parked[i]  <= 1'b0;
          cnt[i]     <= enqDelay;
          opQ[i]     <= enqOp;
          tagQ[i]    <= enqTag;
          psn[i]     <= enqHit;
          for (int s = 0; s < NSRC; s++) srcQ[i][s] <= enqSrcTags[s*TAG_W +: TAG_W];
        end else if (selMask[i]) begin
          if (strobes.fireReplay) begin
            parked[i] <= 1'b1;
            psn[i]    <= '0;
          end else begin
            occMask[i] <= 1'b0;
          end
        end else if (reschedHit[i]) begin
          parked[i] <= 1'b0;
          cnt[i]    <= reschedDelay;
          psn[i]    <= hitNow[i];
        end else if (occMask[i] && !parked[i]) begin
          psn[i] <= psn[i] | hitNow[i];
          if (cnt[i] != '0) cnt[i] <= cnt[i] - DLY_W'(1);
        end
      end
    end
  end

  // R4: control never enqueues into an occupied slot
  assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.enq |-> (occMask & enqSel) == '0);

  // R5: an op sent to the unit carries no poisoned source
  assert_poison_blocks_R5: assert property (@(posedge clk) disable iff (!rstN)
    issueValid |-> (poisonMask & selMask) == '0);

  // R7: a parked entry is never chosen
  assert_parked_never_fires_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.fire |-> (parked & selMask) == '0);

  for (genvar g = 0; g < DEPTH; g++) begin : gChk
    // R2: a counting entry loses exactly one per cycle
    assert_countdown_R2: assert property (@(posedge clk) disable iff (!rstN)
      (occMask[g] && !parked[g] && cnt[g] != '0) |=> cnt[g] == $past(cnt[g]) - DLY_W'(1));
    // R3: a ready entry that did not leave is still ready next cycle
    assert_loser_waits_R3: assert property (@(posedge clk) disable iff (!rstN)
      (readyMask[g] && !selMask[g]) |=> readyMask[g]);
  end
endmodule

// File: rtl/countdown_issue_queue.sv
module countdown_issue_queue
  import cq_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int OP_W  = 8,
  parameter int TAG_W = 6,
  parameter int DLY_W = 4,
  parameter int NSRC  = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  enqValid,
  input  logic [OP_W-1:0]       enqOp,
  input  logic [TAG_W-1:0]      enqTag,
  input  logic [DLY_W-1:0]      enqDelay,
  input  logic [NSRC*TAG_W-1:0] enqSrcTags,
  output logic                  enqFull,
  output logic                  issueValid,
  output logic [OP_W-1:0]       issueOp,
  output logic [TAG_W-1:0]      issueTag,
  input  logic                  poisonValid,
  input  logic [TAG_W-1:0]      poisonTag,
  output logic                  replayValid,
  output logic [TAG_W-1:0]      replayTag,
  input  logic                  reschedValid,
  input  logic [TAG_W-1:0]      reschedTag,
  input  logic [DLY_W-1:0]      reschedDelay
);
  cqStrobes_t       strobes;
  logic [DEPTH-1:0] occMask;
  logic [DEPTH-1:0] readyMask;
  logic [DEPTH-1:0] poisonMask;

  cq_ctrl #(.DEPTH(DEPTH)) i_ctrl (
    .clk(clk), .rstN(rstN), .enqValid(enqValid),
    .occMask(occMask), .readyMask(readyMask), .poisonMask(poisonMask),
    .strobes(strobes), .enqFull(enqFull)
  );

  cq_entries #(
    .DEPTH(DEPTH), .OP_W(OP_W), .TAG_W(TAG_W), .DLY_W(DLY_W), .NSRC(NSRC)
  ) i_entries (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .enqOp(enqOp), .enqTag(enqTag), .enqDelay(enqDelay), .enqSrcTags(enqSrcTags),
    .poisonValid(poisonValid), .poisonTag(poisonTag),
    .reschedValid(reschedValid), .reschedTag(reschedTag), .reschedDelay(reschedDelay),
    .occMask(occMask), .readyMask(readyMask), .poisonMask(poisonMask),
    .issueValid(issueValid), .issueOp(issueOp), .issueTag(issueTag),
    .replayValid(replayValid), .replayTag(replayTag)
  );
endmodule

// File: tb/test_countdown_issue_queue.sv
module test_countdown_issue_queue;
  localparam int DEPTH = 4;
  localparam int OP_W  = 8;
  localparam int TAG_W = 6;
  localparam int DLY_W = 4;
  localparam int NSRC  = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enqValid = 1'b0;
  logic [OP_W-1:0] enqOp = '0;
  logic [TAG_W-1:0] enqTag = '0;
  logic [DLY_W-1:0] enqDelay = '0;
  logic [NSRC*TAG_W-1:0] enqSrcTags = '0;
  logic enqFull, issueValid, replayValid;
  logic [OP_W-1:0] issueOp;
  logic [TAG_W-1:0] issueTag, replayTag;
  logic poisonValid = 1'b0;
  logic [TAG_W-1:0] poisonTag = '0;
  logic reschedValid = 1'b0;
  logic [TAG_W-1:0] reschedTag = '0;
  logic [DLY_W-1:0] reschedDelay = '0;

  int total = 0;
  int fails = 0;

  always #5 clk = ~clk;

  countdown_issue_queue #(
    .DEPTH(DEPTH), .OP_W(OP_W), .TAG_W(TAG_W), .DLY_W(DLY_W), .NSRC(NSRC)
  ) i_countdown_issue_queue (
    .clk(clk), .rstN(rstN), .enqValid(enqValid), .enqOp(enqOp), .enqTag(enqTag),
    .enqDelay(enqDelay), .enqSrcTags(enqSrcTags), .enqFull(enqFull),
    .issueValid(issueValid), .issueOp(issueOp), .issueTag(issueTag),
    .poisonValid(poisonValid), .poisonTag(poisonTag),
    .replayValid(replayValid), .replayTag(replayTag),
    .reschedValid(reschedValid), .reschedTag(reschedTag), .reschedDelay(reschedDelay)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic idle();
    enqValid = 1'b0;
    poisonValid = 1'b0;
    reschedValid = 1'b0;
  endtask

  task automatic drvEnq(input int tag, input int dly, input int s0, input int s1);
    enqValid = 1'b1;
    enqTag = TAG_W'(tag);
    enqOp = OP_W'(tag + 128);
    enqDelay = DLY_W'(dly);
    enqSrcTags = {TAG_W'(s1), TAG_W'(s0)};
  endtask

  task automatic drvPoison(input int tag);
    poisonValid = 1'b1;
    poisonTag = TAG_W'(tag);
  endtask

  task automatic drvResched(input int tag, input int dly);
    reschedValid = 1'b1;
    reschedTag = TAG_W'(tag);
    reschedDelay = DLY_W'(dly);
  endtask

  task automatic expectIssue(input string req, input int tag);
    check(issueValid === 1'b1, {req, " issueValid"}, int'(issueValid), 1);
    check(issueTag == TAG_W'(tag), {req, " issueTag"}, int'(issueTag), tag);
    check(issueOp == OP_W'(tag + 128), {req, " issueOp"}, int'(issueOp), tag + 128);
  endtask

  task automatic expectQuiet(input string req);
    check(issueValid === 1'b0, {req, " no issue"}, int'(issueValid), 0);
    check(replayValid === 1'b0, {req, " no replay"}, int'(replayValid), 0);
  endtask

  task automatic expectReplay(input string req, input int tag);
    check(issueValid === 1'b0, {req, " issue suppressed"}, int'(issueValid), 0);
    check(replayValid === 1'b1, {req, " replayValid"}, int'(replayValid), 1);
    check(replayTag == TAG_W'(tag), {req, " replayTag"}, int'(replayTag), tag);
  endtask

  task automatic testReset();
    check(issueValid === 1'b0, "R1 issueValid", int'(issueValid), 0);
    check(replayValid === 1'b0, "R1 replayValid", int'(replayValid), 0);
    check(enqFull === 1'b0, "R1 enqFull", int'(enqFull), 0);
  endtask

  task automatic testTiming();
    drvEnq(5, 3, 40, 41);
    for (int k = 1; k <= 6; k++) begin
      tick();
      if (k == 1) idle();
      if (k == 4) expectIssue("R2 delay 3", 5);
      else expectQuiet("R2 before/after expiry");
    end
  endtask

  task automatic testOrder();
    drvEnq(1, 2, 42, 43);
    tick(); expectQuiet("R3 cycle1");
    drvEnq(2, 1, 44, 45);
    tick(); idle(); expectQuiet("R3 cycle2");
    tick(); expectIssue("R3 older first", 1);
    tick(); expectIssue("R3 loser next cycle", 2);
    tick(); expectQuiet("R3 after both");
  endtask

  task automatic testFull();
    int seen = 0;
    int next = 20;
    for (int k = 0; k < DEPTH; k++) begin
      check(enqFull === 1'b0, "R4 not full while filling", int'(enqFull), 0);
      drvEnq(20 + k, 10, 46, 47);
      tick();
    end
    idle();
    check(enqFull === 1'b1, "R4 full after DEPTH enqueues", int'(enqFull), 1);
    drvEnq(30, 0, 46, 47);
    tick(); idle();
    for (int k = 0; k < 24; k++) begin
      tick();
      if (issueValid) begin
        seen++;
        check(issueTag == TAG_W'(next), "R4 order and no dropped op", int'(issueTag), next);
        next++;
      end
    end
    check(seen == DEPTH, "R4 issue count", seen, DEPTH);
    check(enqFull === 1'b0, "R4 full clears", int'(enqFull), 0);
  endtask

  task automatic testPoison();
    drvEnq(7, 3, 1, 2);
    tick(); idle(); drvPoison(2);
    tick(); idle();
    tick(); expectQuiet("R5 waiting");
    tick(); expectReplay("R5 stored poison", 7);
    tick(); expectQuiet("R7 parked");
    tick(); drvResched(7, 1);
    tick(); idle(); expectQuiet("R7 after resched");
    tick(); expectIssue("R7 issue after resched", 7);
    tick(); expectQuiet("R7 issued once");
  endtask

  task automatic testSameCycle();
    drvEnq(8, 2, 3, 4);
    tick(); idle();
    tick(); expectQuiet("R6 waiting");
    tick(); drvPoison(4); #1; expectReplay("R6 same-cycle poison", 8);
    tick(); idle();
    tick(); drvResched(8, 0);
    tick(); idle(); expectIssue("R6 issue after resched", 8);
    tick(); expectQuiet("R6 done");
  endtask

  task automatic testNoMatch();
    drvEnq(9, 2, 5, 6);
    tick(); idle(); drvPoison(10);
    tick(); idle(); expectQuiet("R9 waiting");
    tick(); expectIssue("R9 foreign poison ignored", 9);
    tick(); expectQuiet("R9 done");
  endtask

  task automatic testRepeat();
    drvEnq(11, 1, 12, 13);
    tick(); idle(); drvPoison(12);
    tick(); idle(); expectReplay("R8 first replay", 11);
    tick(); drvResched(11, 2);
    tick(); idle(); drvPoison(12); expectQuiet("R8 counting again");
    tick(); idle(); expectQuiet("R8 counting again 2");
    tick(); expectReplay("R8 second replay", 11);
    tick(); drvResched(11, 0);
    tick(); idle(); expectIssue("R8 final issue", 11);
    tick(); expectQuiet("R8 done");
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", total - fails, total);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) tick();
    rstN = 1'b1;
    tick();
    testReset();
    testTiming();
    repeat (2) tick();
    testOrder();
    repeat (2) tick();
    testFull();
    repeat (2) tick();
    testPoison();
    repeat (2) tick();
    testSameCycle();
    repeat (2) tick();
    testNoMatch();
    repeat (2) tick();
    testRepeat();
    repeat (2) tick();
    summary();
    $finish;
  end
endmodule